// File: doc/BRIEF.md
# Headset Detection Mode and Amplifier Gating Controller

This controller sits between the configuration registers of an audio codec and the enables of its analog blocks. A two-bit mode field selects whether the audio path and the headset detection system are powered. A coupling-mode bit states whether the headphone outputs are AC-coupled or capacitor-less. From these settings it drives enable and mute levels for the audio system, the detection system, each headphone amplifier channel and the external microphone bias.

When the audio path is on and detection is on, the debounced headset-present status gates the headphone and bias controls. With no headset in the jack, the headphone channels are silenced and the bias is turned off, even if the registers ask for them. In AC-coupled mode the channels are silenced by forcing mute, which keeps the output DC level. In capacitor-less mode the channels are switched off. With a headset present, or with detection off, the register requests pass through unchanged. All outputs are registered.

Top module: `hs_gate_ctrl`

## Requirements
- R1: While reset is asserted, and for the synchronizer stages after it is released, audio_en_o, detect_en_o, every hp_en_o bit and bias_en_o are 0 and every hp_mute_o bit is 1.
- R2: Mode decoding: chip_mode_i = 2'b00 gives audio off and detection off, 2'b01 gives audio off and detection on, 2'b10 gives audio on and detection off, 2'b11 gives both on. audio_en_o reflects bit 1 and detect_en_o reflects bit 0.
- R3: With audio off (modes 2'b00 and 2'b01), every hp_en_o bit and bias_en_o are 0 and every hp_mute_o bit is 1, whatever the request inputs are.
- R4: The gating condition is mode 2'b11 with hs_present_i = 0. Under gating with cap_less_i = 0 (AC-coupled), every hp_mute_o bit is 1 and each hp_en_o bit follows its request.
- R5: Under gating with cap_less_i = 1 (capless), every hp_en_o bit is 0 and each hp_mute_o bit follows its request.
- R6: Under gating, bias_en_o is 0 in both coupling modes, even when req_bias_en_i is 1.
- R7: In modes 2'b10 and 2'b11 with hs_present_i = 1, hp_en_o, hp_mute_o and bias_en_o equal req_hp_en_i, req_hp_mute_i and req_bias_en_i.
- R8: Every output takes its new value at the first rising clock edge after the inputs change.
- R9: In standby mode (2'b01), detect_en_o stays 1 whether or not a headset is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_mode_i | input | 2 | Requested operating mode (bit 1 audio, bit 0 detection) |
| cap_less_i | input | 1 | 1 = capacitor-less headphone outputs, 0 = AC-coupled |
| hs_present_i | input | 1 | Debounced headset-present status |
| req_hp_en_i | input | NUM_CH | Register-requested headphone channel enables |
| req_hp_mute_i | input | NUM_CH | Register-requested headphone channel mutes |
| req_bias_en_i | input | 1 | Register-requested external microphone bias enable |
| audio_en_o | output | 1 | Audio system enable |
| detect_en_o | output | 1 | Detection system enable |
| hp_en_o | output | NUM_CH | Headphone channel enables |
| hp_mute_o | output | NUM_CH | Headphone channel mutes |
| bias_en_o | output | 1 | External microphone bias enable |

## Verification
The hardest case to reach from the ports is one where automatic gating and the coupling mode both matter. The registers request the amplifiers on and unmuted, with the bias on, while the headset is absent in fully active mode. Only then do the AC-coupled and capless outcomes differ, and only then is the bias override visible. The stimulus sweeps every combination of mode, coupling bit, presence and request pattern back to back, so each gated vector sits next to ungated neighbours. A stale register or a wrong priority therefore shows up on the very next edge.

// File: rtl/hs_gate_pkg.sv
package hs_gate_pkg;

  // Operating mode: bit 1 powers the audio path, bit 0 the detection system.
  typedef enum logic [1:0] {
    MODE_OFF          = 2'b00,
    MODE_STANDBY      = 2'b01,
    MODE_ACTIVE_NODET = 2'b10,
    MODE_ACTIVE_DET   = 2'b11
  } chip_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/hs_mode_decode.sv
module hs_mode_decode
  import hs_gate_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              audio_on_o,
  output logic              det_on_o
);

  chip_mode_e mode;

  always_comb begin
    mode       = chip_mode_e'(mode_i);
    audio_on_o = 1'b0;
    det_on_o   = 1'b0;
    case (mode)
      MODE_OFF: begin
        audio_on_o = 1'b0;
        det_on_o   = 1'b0;
      end
      MODE_STANDBY: begin
        audio_on_o = 1'b0;
        det_on_o   = 1'b1;
      end
      MODE_ACTIVE_NODET: begin
        audio_on_o = 1'b1;
        det_on_o   = 1'b0;
      end
      MODE_ACTIVE_DET: begin
        audio_on_o = 1'b1;
        det_on_o   = 1'b1;
      end
      default: begin
        audio_on_o = 1'b0;
        det_on_o   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/hs_gate_logic.sv
module hs_gate_logic #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              audio_on_i,
  input  logic              det_on_i,
  input  logic              cap_less_i,
  input  logic              hs_present_i,
  input  logic [NUM_CH-1:0] req_hp_en_i,
  input  logic [NUM_CH-1:0] req_hp_mute_i,
  input  logic              req_bias_en_i,
  output logic [NUM_CH-1:0] hp_en_d_o,
  output logic [NUM_CH-1:0] hp_mute_d_o,
  output logic              bias_en_d_o
);

  logic gate_auto;
  logic gate_mute;
  logic gate_off;

  // Automatic gating: active audio, detection running, jack empty.
  always_comb begin
    gate_auto = audio_on_i & det_on_i & ~hs_present_i;
    gate_mute = gate_auto & ~cap_less_i;
    gate_off  = gate_auto &  cap_less_i;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_comb begin
      hp_en_d_o[ch]   = audio_on_i & req_hp_en_i[ch] & ~gate_off;
      hp_mute_d_o[ch] = ~audio_on_i | req_hp_mute_i[ch] | gate_mute;
    end
  end

  always_comb begin
    bias_en_d_o = audio_on_i & req_bias_en_i & ~gate_auto;
  end

endmodule

// File: rtl/hs_out_reg.sv
module hs_out_reg #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic              audio_on_i,
  input  logic              det_on_i,
  input  logic [NUM_CH-1:0] hp_en_d_i,
  input  logic [NUM_CH-1:0] hp_mute_d_i,
  input  logic              bias_en_d_i,
  output logic              audio_en_o,
  output logic              detect_en_o,
  output logic [NUM_CH-1:0] hp_en_o,
  output logic [NUM_CH-1:0] hp_mute_o,
  output logic              bias_en_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      audio_en_o  <= 1'b0;
      detect_en_o <= 1'b0;
      bias_en_o   <= 1'b0;
    end else if (upd_en_i) begin
      audio_en_o  <= audio_on_i;
      detect_en_o <= det_on_i;
      bias_en_o   <= bias_en_d_i;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan_q
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hp_en_o[ch]   <= 1'b0;
        hp_mute_o[ch] <= 1'b1;
      end else if (upd_en_i) begin
        hp_en_o[ch]   <= hp_en_d_i[ch];
        hp_mute_o[ch] <= hp_mute_d_i[ch];
      end
    end
  end

endmodule

// File: rtl/hs_gate_ctrl.sv
module hs_gate_ctrl
  import hs_gate_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        chip_mode_i,
  input  logic              cap_less_i,
  input  logic              hs_present_i,
  input  logic [NUM_CH-1:0] req_hp_en_i,
  input  logic [NUM_CH-1:0] req_hp_mute_i,
  input  logic              req_bias_en_i,
  output logic              audio_en_o,
  output logic              detect_en_o,
  output logic [NUM_CH-1:0] hp_en_o,
  output logic [NUM_CH-1:0] hp_mute_o,
  output logic              bias_en_o
);

  logic              rst_sync_n;
  logic              audio_on;
  logic              det_on;
  logic [NUM_CH-1:0] hp_en_d;
  logic [NUM_CH-1:0] hp_mute_d;
  logic              bias_en_d;
  logic              upd_en;

  // Outputs follow the inputs on every edge once out of reset.
  assign upd_en = 1'b1;

  hs_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  hs_mode_decode u_decode (
    .mode_i     (chip_mode_i),
    .audio_on_o (audio_on),
    .det_on_o   (det_on)
  );

  hs_gate_logic #(
    .NUM_CH (NUM_CH)
  ) u_gate (
    .audio_on_i    (audio_on),
    .det_on_i      (det_on),
    .cap_less_i    (cap_less_i),
    .hs_present_i  (hs_present_i),
    .req_hp_en_i   (req_hp_en_i),
    .req_hp_mute_i (req_hp_mute_i),
    .req_bias_en_i (req_bias_en_i),
    .hp_en_d_o     (hp_en_d),
    .hp_mute_d_o   (hp_mute_d),
    .bias_en_d_o   (bias_en_d)
  );

  hs_out_reg #(
    .NUM_CH (NUM_CH)
  ) u_oreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .upd_en_i    (upd_en),
    .audio_on_i  (audio_on),
    .det_on_i    (det_on),
    .hp_en_d_i   (hp_en_d),
    .hp_mute_d_i (hp_mute_d),
    .bias_en_d_i (bias_en_d),
    .audio_en_o  (audio_en_o),
    .detect_en_o (detect_en_o),
    .hp_en_o     (hp_en_o),
    .hp_mute_o   (hp_mute_o),
    .bias_en_o   (bias_en_o)
  );

endmodule

// File: rtl/hs_gate_chk.sv
module hs_gate_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_sync_n,
  input logic [1:0]        chip_mode_i,
  input logic              cap_less_i,
  input logic              hs_present_i,
  input logic [NUM_CH-1:0] req_hp_en_i,
  input logic [NUM_CH-1:0] req_hp_mute_i,
  input logic              req_bias_en_i,
  input logic              audio_en_o,
  input logic              detect_en_o,
  input logic [NUM_CH-1:0] hp_en_o,
  input logic [NUM_CH-1:0] hp_mute_o,
  input logic              bias_en_o
);

  logic gated;
  assign gated = (chip_mode_i == 2'b11) && !hs_present_i;

  assert_mode_decode_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    1'b1 |=> (audio_en_o == $past(chip_mode_i[1])) && (detect_en_o == $past(chip_mode_i[0])));

  assert_audio_off_R3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !chip_mode_i[1] |=> (hp_en_o == '0) && (hp_mute_o == '1) && !bias_en_o);

  assert_ac_mute_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (gated && !cap_less_i) |=> (hp_mute_o == '1) && (hp_en_o == $past(req_hp_en_i)));

  assert_capless_off_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (gated && cap_less_i) |=> (hp_en_o == '0) && (hp_mute_o == $past(req_hp_mute_i)));

  assert_bias_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    gated |=> !bias_en_o);

  assert_follow_req_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (chip_mode_i[1] && hs_present_i) |=>
      (hp_en_o == $past(req_hp_en_i)) && (hp_mute_o == $past(req_hp_mute_i))
      && (bias_en_o == $past(req_bias_en_i)));

  assert_standby_detect_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (chip_mode_i == 2'b01) |=> detect_en_o && !audio_en_o);

endmodule

bind hs_gate_ctrl hs_gate_chk #(
  .NUM_CH (NUM_CH)
) u_chk (
  .clk_i         (clk_i),
  .rst_sync_n    (rst_sync_n),
  .chip_mode_i   (chip_mode_i),
  .cap_less_i    (cap_less_i),
  .hs_present_i  (hs_present_i),
  .req_hp_en_i   (req_hp_en_i),
  .req_hp_mute_i (req_hp_mute_i),
  .req_bias_en_i (req_bias_en_i),
  .audio_en_o    (audio_en_o),
  .detect_en_o   (detect_en_o),
  .hp_en_o       (hp_en_o),
  .hp_mute_o     (hp_mute_o),
  .bias_en_o     (bias_en_o)
);

// File: tb/hs_gate_ctrl_tb_top.sv
module hs_gate_ctrl_tb_top;

  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_ni;
  logic [1:0]     chip_mode;
  logic           cap_less;
  logic           hs_present;
  logic [NCH-1:0] req_en;
  logic [NCH-1:0] req_mute;
  logic           req_bias;
  logic           audio_en;
  logic           detect_en;
  logic [NCH-1:0] hp_en;
  logic [NCH-1:0] hp_mute;
  logic           bias_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic           audio;
    logic           det;
    logic [NCH-1:0] en;
    logic [NCH-1:0] mute;
    logic           bias;
    string          tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  hs_gate_ctrl #(.NUM_CH(NCH)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .chip_mode_i   (chip_mode),
    .cap_less_i    (cap_less),
    .hs_present_i  (hs_present),
    .req_hp_en_i   (req_en),
    .req_hp_mute_i (req_mute),
    .req_bias_en_i (req_bias),
    .audio_en_o    (audio_en),
    .detect_en_o   (detect_en),
    .hp_en_o       (hp_en),
    .hp_mute_o     (hp_mute),
    .bias_en_o     (bias_en)
  );

  function automatic exp_t model(input logic [1:0] m, input logic cl, input logic hp,
                                 input logic [NCH-1:0] re, input logic [NCH-1:0] rm,
                                 input logic rb);
    exp_t e;
    e.audio = m[1];
    e.det   = m[0];
    if (!m[1]) begin
      e.en = '0; e.mute = '1; e.bias = 1'b0;
      e.tag = (m == 2'b01) ? "R9 R3" : "R3 R2";
    end else if (m[0] && !hp) begin
      e.bias = 1'b0;
      if (cl) begin
        e.en = '0; e.mute = rm; e.tag = "R5 R6";
      end else begin
        e.en = re; e.mute = '1; e.tag = "R4 R6";
      end
    end else begin
      e.en = re; e.mute = rm; e.bias = rb; e.tag = "R7 R2";
    end
    return e;
  endfunction

  task automatic drive(input logic [1:0] m, input logic cl, input logic hp,
                       input logic [NCH-1:0] re, input logic [NCH-1:0] rm, input logic rb);
    @(negedge clk);
    chip_mode = m; cap_less = cl; hs_present = hp;
    req_en = re; req_mute = rm; req_bias = rb;
    exp_q.push_back(model(m, cl, hp, re, rm, rb));
  endtask

  // Monitor: outputs are registered, so the item driven at a falling edge
  // is visible just after the next rising edge (R8).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (audio_en !== e.audio || detect_en !== e.det || hp_en !== e.en ||
            hp_mute !== e.mute || bias_en !== e.bias) begin
          bad++;
          $display("FAIL %s R8: got a=%b d=%b en=%b mu=%b b=%b exp a=%b d=%b en=%b mu=%b b=%b",
                   e.tag, audio_en, detect_en, hp_en, hp_mute, bias_en,
                   e.audio, e.det, e.en, e.mute, e.bias);
        end
      end
    end
  end

  task automatic check_reset(input string when);
    total++;
    if (audio_en !== 1'b0 || detect_en !== 1'b0 || hp_en !== '0 ||
        hp_mute !== '1 || bias_en !== 1'b0) begin
      bad++;
      $display("FAIL R1 (%s): got a=%b d=%b en=%b mu=%b b=%b exp a=0 d=0 en=00 mu=11 b=0",
               when, audio_en, detect_en, hp_en, hp_mute, bias_en);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    chip_mode = 2'b11; cap_less = 1'b0; hs_present = 1'b1;
    req_en = '1; req_mute = '0; req_bias = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset("held");        // R1 with requests that would turn things on
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset("sync stage");  // R1: synchronizer still holds outputs
    repeat (3) @(negedge clk);

    // Exhaustive sweep of mode, coupling, presence and requests.
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 2; p++)
          for (int r = 0; r < 16; r++)
            for (int b = 0; b < 2; b++)
              drive(2'(m), 1'(c), 1'(p), 2'(r), 2'(r >> 2), 1'(b));

    // Headset flips every edge in full active mode: gating must track it (R4 R5 R7).
    for (int k = 0; k < 12; k++)
      drive(2'b11, 1'(k / 6), 1'(k), 2'b11, 2'b00, 1'b1);

    // Standby with presence toggling keeps detection alive (R9).
    for (int k = 0; k < 4; k++)
      drive(2'b01, 1'b1, 1'(k), 2'b11, 2'b00, 1'b1);

    @(posedge clk);
    #3;
    while (exp_q.size() > 0) begin
      @(posedge clk);
      #3;
    end

    // Reset asserted mid-run clears everything (R1).
    @(negedge clk);
    chip_mode = 2'b10; req_en = '1; req_mute = '0; req_bias = 1'b1;
    rst_ni = 1'b0;
    #1;
    check_reset("mid-run");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule